// File: doc/BRIEF.md
# DMA Event Status and Interrupt Unit

This block is the shared status front end for a group of DMA channels. Every channel reports four kinds of event with one-cycle pulses: transfer done, source-side error, destination-side error and configuration error. The block latches each pulse into a sticky per-channel bit in one of four raw status words. It exposes a masked view of each word and folds every masked bit into one registered interrupt line.

Software reaches the block through a simple register port with a write strobe and a read strobe. It clears events by writing ones to a raw word: a single bit after a channel is aborted, or all ones at start-up. The port also reads the live per-channel busy flags, which software consults before starting a channel. A read/write arbitration word resets to zero, the value that means equal priority for all channels. The port has no back-pressure. A write takes effect at the clock edge that samples it. Read data is registered and appears one cycle after the read strobe. There is no streaming data path, so no valid/ready handshake is used.

Top module: `dma_evt_status`

## Requirements
- R1: After reset all four raw words, the arbitration word, the read data register and `irq` are zero.
- R2: A pulse on bit n of an event input sets bit n of that event's raw word at the sampling edge, and the bit stays set until cleared. The raw words are at offset 0x810 (done), 0x814 (source error), 0x818 (destination error) and 0x81C (configuration error), with bit n meaning channel n.
- R3: A write to a raw word clears each bit written as 1 and leaves bits written as 0 unchanged. The other three words are not affected.
- R4: If a pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: The status words at 0x800, 0x804, 0x808 and 0x80C, in the same class order, read as the raw word ANDed with the parameter `IRQ_EN_MASK` (all ones by default). Writes to them change nothing.
- R6: `irq` is a register. It is high in the cycle after any enabled status bit of any class is set, and low in the cycle after none is.
- R7: Offset 0x820 reads the `ch_busy` input, with bit n meaning channel n.
- R8: Offset 0x828 is an `ARB_W`-bit read/write word that resets to zero.
- R9: Bits at and above `N` read as zero in every word except the arbitration word. A write of 0xFFFFFFFF to a raw word clears every channel.
- R10: Reads of any other offset return zero.
- R11: `reg_rdata` loads the addressed value at the edge that samples `reg_rd` high, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| ev_done | input | N | Transfer-done pulses, one per channel |
| ev_src_err | input | N | Source-error pulses |
| ev_dst_err | input | N | Destination-error pulses |
| ev_cfg_err | input | N | Configuration-error pulses |
| ch_busy | input | N | Live per-channel busy flags |
| irq | output | 1 | Combined registered interrupt |

## Verification
An event pulse or a clearing write changes a raw bit at the edge that samples it. `irq` follows one edge later, and read data appears after the edge that samples `reg_rd`. The bench drives every input just after a rising edge. It samples outputs one time unit after the next edge, which is the first point at which the result is due. It reads `irq` on both sides of the edge where it must change, so a one-cycle skew is caught. Raw contents are checked only through reads issued in later cycles with no event pulse pending.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

  // Event classes; the value is the index of the class's word in each view
  typedef enum logic [1:0] {
    CLS_DONE    = 2'd0,
    CLS_SRC_ERR = 2'd1,
    CLS_DST_ERR = 2'd2,
    CLS_CFG_ERR = 2'd3
  } evt_class_e;

  localparam int NUM_CLS   = 4;
  localparam int WORD_STEP = 4;

  // Byte offsets of the register views
  localparam int OFS_STAT_BASE = 32'h800;
  localparam int OFS_RAW_BASE  = 32'h810;
  localparam int OFS_BUSY      = 32'h820;
  localparam int OFS_ARB       = 32'h828;

endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
  import dma_evt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_CLS-1:0] stat_sel,
  output logic [NUM_CLS-1:0] raw_sel,
  output logic               busy_sel,
  output logic               arb_sel
);

  // Per-class selects are one-hot by construction of distinct offsets
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    assign stat_sel[c] = (addr == ADDR_W'(OFS_STAT_BASE + WORD_STEP * c));
    assign raw_sel[c]  = (addr == ADDR_W'(OFS_RAW_BASE + WORD_STEP * c));
  end

  assign busy_sel = (addr == ADDR_W'(OFS_BUSY));
  assign arb_sel  = (addr == ADDR_W'(OFS_ARB));

endmodule

// File: rtl/evt_raw_bank.sv
module evt_raw_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] raw
);

  logic [N-1:0] clr_eff;

  assign clr_eff = clr_en ? clr_mask : '0;

  // A new event is ORed in after the clear, so set wins on a collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~clr_eff) | ev;
  end

endmodule

// File: rtl/evt_irq_combine.sv
module evt_irq_combine #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] stat_flat,
  output logic             irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |stat_flat;
  end

endmodule

// File: rtl/dma_evt_status.sv
module dma_evt_status
  import dma_evt_pkg::*;
#(
  parameter int          N           = 32,
  parameter int          DW          = 32,
  parameter int          ADDR_W      = 12,
  parameter int          ARB_W       = 32,
  parameter logic [31:0] IRQ_EN_MASK = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [N-1:0]      ev_done,
  input  logic [N-1:0]      ev_src_err,
  input  logic [N-1:0]      ev_dst_err,
  input  logic [N-1:0]      ev_cfg_err,
  input  logic [N-1:0]      ch_busy,
  output logic              irq
);

  localparam int FLAT_W = NUM_CLS * N;
  localparam logic [N-1:0] EN_MASK = IRQ_EN_MASK[N-1:0];

  logic [FLAT_W-1:0]  ev_flat;
  logic [FLAT_W-1:0]  raw_flat;
  logic [FLAT_W-1:0]  stat_flat;
  logic [NUM_CLS-1:0] stat_sel;
  logic [NUM_CLS-1:0] raw_sel;
  logic               busy_sel;
  logic               arb_sel;
  logic [ARB_W-1:0]   arb_q;
  logic [DW-1:0]      rd_val;

  assign ev_flat = {ev_cfg_err, ev_dst_err, ev_src_err, ev_done};

  evt_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (reg_addr),
    .stat_sel (stat_sel),
    .raw_sel  (raw_sel),
    .busy_sel (busy_sel),
    .arb_sel  (arb_sel)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_bank
    evt_raw_bank #(.N(N)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev_flat[c*N +: N]),
      .clr_en   (reg_wr && raw_sel[c]),
      .clr_mask (reg_wdata[N-1:0]),
      .raw      (raw_flat[c*N +: N])
    );
    assign stat_flat[c*N +: N] = raw_flat[c*N +: N] & EN_MASK;
  end

  evt_irq_combine #(.WIDTH(FLAT_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_flat (stat_flat),
    .irq       (irq)
  );

  // Arbitration word: plain storage, zero means equal priority
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 arb_q <= '0;
    else if (reg_wr && arb_sel) arb_q <= reg_wdata[ARB_W-1:0];
  end

  // OR-combined read mux over one-hot selects; unmapped offsets give zero
  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (stat_sel[c]) rd_val[N-1:0] = rd_val[N-1:0] | stat_flat[c*N +: N];
      if (raw_sel[c])  rd_val[N-1:0] = rd_val[N-1:0] | raw_flat[c*N +: N];
    end
    if (busy_sel) rd_val[N-1:0]     = rd_val[N-1:0] | ch_busy;
    if (arb_sel)  rd_val[ARB_W-1:0] = rd_val[ARB_W-1:0] | arb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

endmodule

// File: rtl/dma_evt_status_chk.sv
module dma_evt_status_chk
  import dma_evt_pkg::*;
#(
  parameter int          N           = 32,
  parameter int          DW          = 32,
  parameter int          ADDR_W      = 12,
  parameter logic [31:0] IRQ_EN_MASK = 32'hFFFF_FFFF
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [DW-1:0]        reg_wdata,
  input logic [DW-1:0]        reg_rdata,
  input logic [NUM_CLS*N-1:0] ev_flat,
  input logic [NUM_CLS*N-1:0] raw_flat,
  input logic                 irq
);

  localparam logic [N-1:0] EN_MASK = IRQ_EN_MASK[N-1:0];

  logic               armed;
  logic [N-1:0]       clr_m  [NUM_CLS];
  logic [NUM_CLS-1:0] stat_wr;
  logic               any_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    any_en = 1'b0;
    for (int c = 0; c < NUM_CLS; c++) begin
      clr_m[c]   = (reg_wr && reg_addr == ADDR_W'(OFS_RAW_BASE + WORD_STEP * c)) ?
                   reg_wdata[N-1:0] : '0;
      stat_wr[c] = reg_wr && reg_addr == ADDR_W'(OFS_STAT_BASE + WORD_STEP * c);
      any_en     = any_en | (|(raw_flat[c*N +: N] & EN_MASK));
    end
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    // R2 R4
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> ((raw_flat[c*N +: N] & $past(ev_flat[c*N +: N])) == $past(ev_flat[c*N +: N])));
    // R3
    raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> ((raw_flat[c*N +: N] & $past(clr_m[c]) & ~$past(ev_flat[c*N +: N])) == '0));
    // R2
    raw_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> ((raw_flat[c*N +: N] & ~$past(raw_flat[c*N +: N]) & ~$past(ev_flat[c*N +: N])) == '0));
    // R5
    stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && stat_wr[c] && clr_m[c] == '0) |=>
        (raw_flat[c*N +: N] == ($past(raw_flat[c*N +: N]) | $past(ev_flat[c*N +: N]))));
  end

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (irq == $past(any_en)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(reg_rd)) |-> $stable(reg_rdata));

endmodule

bind dma_evt_status dma_evt_status_chk #(
  .N(N), .DW(DW), .ADDR_W(ADDR_W), .IRQ_EN_MASK(IRQ_EN_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .ev_flat(ev_flat), .raw_flat(raw_flat), .irq(irq)
);

// File: tb/test_dma_evt_status.sv
module test_dma_evt_status;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int NV = 11;

  // Vector fields: {class[1:0], event mask[7:0], clear mask[7:0], expected raw[7:0]}
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 8'h01, 8'h00, 8'h01},
    {2'd0, 8'h80, 8'h00, 8'h81},
    {2'd0, 8'h00, 8'h01, 8'h80},
    {2'd0, 8'h04, 8'h04, 8'h84},
    {2'd1, 8'h3C, 8'h00, 8'h3C},
    {2'd1, 8'h00, 8'h0C, 8'h30},
    {2'd2, 8'hFF, 8'h00, 8'hFF},
    {2'd2, 8'h10, 8'hFF, 8'h10},
    {2'd3, 8'h02, 8'h00, 8'h02},
    {2'd3, 8'h00, 8'h00, 8'h02},
    {2'd1, 8'h00, 8'hFF, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [N-1:0]  ev_done = '0, ev_src_err = '0, ev_dst_err = '0, ev_cfg_err = '0;
  logic [N-1:0]  ch_busy = '0;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [DW-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_evt_status #(.N(N), .DW(DW), .ADDR_W(AW), .ARB_W(32)) i_dma_evt_status (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_done(ev_done), .ev_src_err(ev_src_err), .ev_dst_err(ev_dst_err),
    .ev_cfg_err(ev_cfg_err), .ch_busy(ch_busy), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    reg_addr = a; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic set_ev(int cls, logic [N-1:0] m);
    ev_done    = (cls == 0) ? m : '0;
    ev_src_err = (cls == 1) ? m : '0;
    ev_dst_err = (cls == 2) ? m : '0;
    ev_cfg_err = (cls == 3) ? m : '0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rdata", reg_rdata, 32'd0);
    rst_n = 1'b1;
    tick();
    for (int c = 0; c < 4; c++) begin
      rd(AW'(12'h810 + 4*c), rv);
      check("R1 raw", rv, 32'd0);
    end
    rd(12'h828, rv);
    check("R1 R8 arb reset", rv, 32'd0);

    // Vector walk: R2 R3 R4 R5, event and clearing write in the same cycle
    for (int i = 0; i < NV; i++) begin
      int cls;
      cls = int'(VEC[i][25:24]);
      set_ev(cls, VEC[i][23:16]);
      reg_addr = AW'(12'h810 + 4*cls); reg_wdata = {24'd0, VEC[i][15:8]}; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0; set_ev(0, '0);
      rd(AW'(12'h810 + 4*cls), rv);
      check("R2 R3 R4 raw vector", rv, {24'd0, VEC[i][7:0]});
      rd(AW'(12'h800 + 4*cls), rv);
      check("R5 status vector", rv, {24'd0, VEC[i][7:0]});
    end

    // R3 other classes untouched by later writes
    rd(12'h810, rv); check("R3 cross-class done", rv, 32'h84);
    rd(12'h818, rv); check("R3 cross-class dst", rv, 32'h10);
    rd(12'h81C, rv); check("R3 cross-class cfg", rv, 32'h02);

    // R5 write to status view ignored
    wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h810, rv); check("R5 status write ignored", rv, 32'h84);

    // R6 irq high while events pending, falls one cycle after full clear
    check("R6 irq pending", {31'd0, irq}, 32'd1);
    for (int c = 0; c < 4; c++) begin
      reg_addr = AW'(12'h810 + 4*c); reg_wdata = 32'hFFFF_FFFF; reg_wr = 1'b1;
      tick();
    end
    reg_wr = 1'b0;
    check("R6 irq still set at clear edge", {31'd0, irq}, 32'd1);
    tick();
    check("R6 irq low after clear", {31'd0, irq}, 32'd0);

    // R6 rise latency: pulse source error on channel 3
    ev_src_err = 8'h08;
    tick();
    ev_src_err = '0;
    check("R6 irq not yet", {31'd0, irq}, 32'd0);
    tick();
    check("R6 irq rises", {31'd0, irq}, 32'd1);
    // abort-style clear of channel 3 in all four words
    for (int c = 0; c < 4; c++) wr(AW'(12'h810 + 4*c), 32'h0000_0008);
    rd(12'h814, rv); check("R3 single-channel clear", rv, 32'd0);
    check("R6 irq low after abort clear", {31'd0, irq}, 32'd0);

    // R9 bits above N read zero, all-ones clears everything
    ev_done = '1; ev_cfg_err = '1;
    tick();
    ev_done = '0; ev_cfg_err = '0;
    rd(12'h810, rv); check("R9 upper bits zero", rv, 32'h0000_00FF);
    wr(12'h81C, 32'hFFFF_FFFF);
    rd(12'h81C, rv); check("R9 all-ones clear", rv, 32'd0);
    wr(12'h810, 32'hFFFF_FFFF);

    // R7 busy view
    ch_busy = 8'hA5;
    rd(12'h820, rv); check("R7 busy", rv, 32'h0000_00A5);

    // R11 read data holds without a read strobe
    ch_busy = 8'h3C;
    tick(); tick();
    check("R11 rdata hold", reg_rdata, 32'h0000_00A5);

    // R8 arbitration storage
    wr(12'h828, 32'hDEAD_BEEF);
    rd(12'h828, rv); check("R8 arb readback", rv, 32'hDEAD_BEEF);
    wr(12'h828, 32'd0);
    rd(12'h828, rv); check("R8 arb zero", rv, 32'd0);

    // R10 unmapped offsets
    rd(12'h824, rv); check("R10 unmapped 0x824", rv, 32'd0);
    rd(12'h000, rv); check("R10 unmapped 0x000", rv, 32'd0);
    rd(12'h82C, rv); check("R10 unmapped 0x82C", rv, 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule